// File: doc/BRIEF.md
# Pixel Matrix Row Readout Sequencer

This block steps through the rows of an active pixel matrix and, for each row, runs a correlated double sample sequence. It turns on the selected row's gate line and fires a first strobe to the column current readout, which then holds signal plus pedestal. It then pulses that row's clear line to remove the collected charge. Last, it fires a second strobe to the readout, which then holds the pedestal alone. Gate and clear come out as separate per-row enable vectors. External high-voltage switcher banks drive the matrix from these two vectors.

A start pulse launches one frame, beginning at row 0. After the last row the block raises a one-cycle frame-done flag. It then goes idle, or starts the next frame at once when continuous mode is set. The settle time and the clear width are counted in clock cycles from two timing inputs. A build parameter selects one or two rows active at the same time.

Top module: `pix_row_seq`

## Requirements
- R1: During and right after reset the block is idle: gate and clear vectors are all zero, both strobes and frame-done are low, and the row index is 0.
- R2: A start pulse seen while idle begins a frame in the next cycle at row 0. While a row is being read, only the gate bit(s) of that row are high and every other gate bit is low.
- R3: With S = max(settle input, 1), the row gate is high for exactly S cycles before the signal strobe, and it stays high through that strobe.
- R4: Per row the order is: signal strobe for 1 cycle, then clear for C = max(clear-width input, 1) cycles, then pedestal strobe for 1 cycle. Each strobe is exactly one clock wide. One row therefore takes S + C + 2 cycles.
- R5: Clear is never high in the same cycle as either strobe, and it is high only on the row(s) whose gate is high.
- R6: The row index holds steady for the whole sequence of a row. Rows are visited in ascending order, stepping by 1 (single mode) or by 2 (dual mode), with no gap cycles between rows.
- R7: In the cycle after the last row's pedestal strobe, frame-done is high for exactly one cycle. In that cycle all gates are low and the row index is 0.
- R8: After frame-done the block goes idle if the continuous input is low. If it is high, the next frame starts in the next cycle at row 0 without a start pulse.
- R9: A start pulse while a frame is running has no effect on the sequence.
- R10: In dual mode, rows 2k and 2k+1 are gated and cleared together, the row index shows 2k, and a frame has ROWS/2 row slots.
- R11: A timing input of zero acts as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of frame, taken only when idle |
| cont_i | input | 1 | Continuous mode, sampled in the frame-done cycle |
| tset_i | input | CNT_W | Gate settle cycles before the signal strobe |
| tclr_i | input | CNT_W | Clear pulse width in cycles |
| row_o | output | ROW_W | Index of the row being read (first row of a pair in dual mode) |
| gate_o | output | ROWS | Per-row gate enables |
| clear_o | output | ROWS | Per-row clear enables |
| samp_sig_o | output | 1 | Strobe: sample signal plus pedestal |
| samp_ped_o | output | 1 | Strobe: sample pedestal only |
| frame_done_o | output | 1 | One-cycle end-of-frame flag |

## Verification
The properties assume that the two timing inputs stay constant for the whole frame and that continuous mode changes only between frames. They also assume that ROWS is even when dual mode is used. The stimulus draws the settle and clear values at random from $urandom before each frame, including zero, and holds them until the frame ends. It sets continuous mode at the start of a frame and clears it at the start of the last one. Stray start pulses are the only input toggled mid-frame.

// File: rtl/pix_rs_pkg.sv
package pix_rs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_SIG,
        PH_CLEAR,
        PH_PED,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/pix_rs_ctrl.sv
module pix_rs_ctrl
    import pix_rs_pkg::*;
#(
    parameter int ROWS     = 128,
    parameter bit DUAL_ROW = 1'b0,
    parameter int CNT_W    = 8,
    parameter int ROW_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [CNT_W-1:0] tset_i,
    input  logic [CNT_W-1:0] tclr_i,
    output phase_e           phase_o,
    output logic [ROW_W-1:0] row_o
);

    localparam int STEP = DUAL_ROW ? 2 : 1;
    localparam logic [ROW_W-1:0] ROW_STEP = ROW_W'(STEP);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - STEP);

    typedef struct packed {
        phase_e           ph;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
    } seq_s;

    seq_s seq_d, seq_q;

    // zero on a timing input acts as one cycle; counters load len-1
    logic [CNT_W-1:0] set_load, clr_load;
    assign set_load = (tset_i == '0) ? '0 : tset_i - CNT_W'(1);
    assign clr_load = (tclr_i == '0) ? '0 : tclr_i - CNT_W'(1);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.ph  = PH_SETTLE;
                    seq_d.row = '0;
                    seq_d.cnt = set_load;
                end
            end
            PH_SETTLE: begin
                if (seq_q.cnt == '0) seq_d.ph = PH_SIG;
                else seq_d.cnt = seq_q.cnt - CNT_W'(1);
            end
            PH_SIG: begin
                seq_d.ph  = PH_CLEAR;
                seq_d.cnt = clr_load;
            end
            PH_CLEAR: begin
                if (seq_q.cnt == '0) seq_d.ph = PH_PED;
                else seq_d.cnt = seq_q.cnt - CNT_W'(1);
            end
            PH_PED: begin
                if (seq_q.row == ROW_LAST) begin
                    seq_d.ph  = PH_DONE;
                    seq_d.row = '0;
                end else begin
                    seq_d.ph  = PH_SETTLE;
                    seq_d.row = seq_q.row + ROW_STEP;
                    seq_d.cnt = set_load;
                end
            end
            PH_DONE: begin
                if (cont_i) begin
                    seq_d.ph  = PH_SETTLE;
                    seq_d.row = '0;
                    seq_d.cnt = set_load;
                end else begin
                    seq_d.ph = PH_IDLE;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ph  <= PH_IDLE;
            seq_q.row <= '0;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.ph;
    assign row_o   = seq_q.row;

endmodule

// File: rtl/pix_rs_row_decode.sv
module pix_rs_row_decode #(
    parameter int ROWS     = 128,
    parameter bit DUAL_ROW = 1'b0,
    parameter int ROW_W    = 7
) (
    input  logic [ROW_W-1:0] row_i,
    input  logic             gate_on_i,
    input  logic             clr_on_i,
    output logic [ROWS-1:0]  gate_o,
    output logic [ROWS-1:0]  clr_o
);

    localparam int STEP = DUAL_ROW ? 2 : 1;

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        // first row of the slot this line belongs to
        localparam int BASE = (i / STEP) * STEP;
        logic hit;
        assign hit       = (row_i == ROW_W'(BASE));
        assign gate_o[i] = gate_on_i && hit;
        assign clr_o[i]  = clr_on_i && hit;
    end

endmodule

// File: rtl/pix_row_seq.sv
module pix_row_seq
    import pix_rs_pkg::*;
#(
    parameter int ROWS     = 128,
    parameter bit DUAL_ROW = 1'b0,
    parameter int CNT_W    = 8,
    localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [CNT_W-1:0] tset_i,
    input  logic [CNT_W-1:0] tclr_i,
    output logic [ROW_W-1:0] row_o,
    output logic [ROWS-1:0]  gate_o,
    output logic [ROWS-1:0]  clear_o,
    output logic             samp_sig_o,
    output logic             samp_ped_o,
    output logic             frame_done_o
);

    phase_e ph;
    logic   gate_on, clr_on;

    pix_rs_ctrl #(
        .ROWS(ROWS), .DUAL_ROW(DUAL_ROW), .CNT_W(CNT_W), .ROW_W(ROW_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .tset_i(tset_i), .tclr_i(tclr_i), .phase_o(ph), .row_o(row_o)
    );

    assign gate_on = (ph == PH_SETTLE) || (ph == PH_SIG) ||
                     (ph == PH_CLEAR)  || (ph == PH_PED);
    assign clr_on  = (ph == PH_CLEAR);

    pix_rs_row_decode #(
        .ROWS(ROWS), .DUAL_ROW(DUAL_ROW), .ROW_W(ROW_W)
    ) u_dec (
        .row_i(row_o), .gate_on_i(gate_on), .clr_on_i(clr_on),
        .gate_o(gate_o), .clr_o(clear_o)
    );

    assign samp_sig_o   = (ph == PH_SIG);
    assign samp_ped_o   = (ph == PH_PED);
    assign frame_done_o = (ph == PH_DONE);

endmodule

// File: rtl/pix_row_seq_chk.sv
module pix_row_seq_chk #(
    parameter int ROWS     = 128,
    parameter bit DUAL_ROW = 1'b0,
    parameter int ROW_W    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ROW_W-1:0] row_o,
    input logic [ROWS-1:0]  gate_o,
    input logic [ROWS-1:0]  clear_o,
    input logic             samp_sig_o,
    input logic             samp_ped_o,
    input logic             frame_done_o
);

    localparam int ACT = DUAL_ROW ? 2 : 1;

    // R2
    gate_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o != '0) |-> ($countones(gate_o) == ACT));

    // R3
    sig_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_sig_o |-> (gate_o != '0) && ($past(gate_o) == gate_o));

    // R4
    sig_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_sig_o |=> !samp_sig_o);

    // R4
    ped_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_ped_o |=> !samp_ped_o);

    // R5
    clear_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_o != '0) |-> !(samp_sig_o || samp_ped_o));

    // R5
    clear_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_o & ~gate_o) == '0);

    // R6
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_ped_o |-> $stable(row_o));

    // R7
    done_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (gate_o == '0) && !samp_sig_o && !samp_ped_o);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

endmodule

bind pix_row_seq pix_row_seq_chk #(
    .ROWS(ROWS), .DUAL_ROW(DUAL_ROW), .ROW_W(ROW_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .row_o(row_o), .gate_o(gate_o),
    .clear_o(clear_o), .samp_sig_o(samp_sig_o), .samp_ped_o(samp_ped_o),
    .frame_done_o(frame_done_o)
);

// File: tb/test_pix_row_seq.sv
module test_pix_row_seq;

    localparam int ROWS_A = 128;
    localparam int ROWS_B = 16;
    localparam int CW     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0, start_b = 1'b0, cont = 1'b0;
    logic [CW-1:0] tset = '0, tclr = '0;

    logic [6:0]        row_a;
    logic [ROWS_A-1:0] gate_a, clr_a;
    logic              sig_a, ped_a, done_a;
    logic [3:0]        row_b;
    logic [ROWS_B-1:0] gate_b, clr_b;
    logic              sig_b, ped_b, done_b;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    pix_row_seq #(.ROWS(ROWS_A), .DUAL_ROW(1'b0), .CNT_W(CW)) i_pix_row_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .cont_i(cont),
        .tset_i(tset), .tclr_i(tclr), .row_o(row_a), .gate_o(gate_a),
        .clear_o(clr_a), .samp_sig_o(sig_a), .samp_ped_o(ped_a),
        .frame_done_o(done_a));

    pix_row_seq #(.ROWS(ROWS_B), .DUAL_ROW(1'b1), .CNT_W(CW)) i_pix_row_seq_dual (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .cont_i(cont),
        .tset_i(tset), .tclr_i(tclr), .row_o(row_b), .gate_o(gate_b),
        .clear_o(clr_b), .samp_sig_o(sig_b), .samp_ped_o(ped_b),
        .frame_done_o(done_b));

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // sample the chosen instance's outputs, zero-extended
    task automatic sample(input bit dual, output logic [127:0] g, output logic [127:0] c,
                          output logic [127:0] r, output logic [127:0] st);
        if (dual) begin
            g = 128'(gate_b); c = 128'(clr_b); r = 128'(row_b);
            st = 128'({sig_b, ped_b, done_b});
        end else begin
            g = 128'(gate_a); c = 128'(clr_a); r = 128'(row_a);
            st = 128'({sig_a, ped_a, done_a});
        end
    endtask

    task automatic idle_check(input bit dual, input string req);
        logic [127:0] g, c, r, st;
        sample(dual, g, c, r, st);
        check(req, "idle gate", g, '0);
        check(req, "idle clear", c, '0);
        check(req, "idle row", r, '0);
        check(req, "idle strobes/done", st, '0);
    endtask

    // run nfr frames back to back; poke = stray start mid-frame
    task automatic run(input bit dual, input int s_in, input int c_in,
                       input int nfr, input bit poke);
        int step = dual ? 2 : 1;
        int nr   = (dual ? ROWS_B : ROWS_A) / step;
        int s    = (s_in == 0) ? 1 : s_in;
        int c    = (c_in == 0) ? 1 : c_in;
        int p    = s + c + 2;
        int f    = nr * p + 1;
        string rq_g = dual ? "R10" : "R2";
        tset = CW'(s_in);
        tclr = CW'(c_in);
        cont = (nfr > 1);
        @(negedge clk);
        if (dual) start_b = 1'b1; else start_a = 1'b1;
        for (int t = 0; t < nfr * f; t++) begin
            logic [127:0] g, cl, r, st, eg, ec, er, est;
            int u = t % f;
            @(negedge clk);
            start_a = 1'b0;
            start_b = 1'b0;
            if (t / f == nfr - 1) cont = 1'b0;
            sample(dual, g, cl, r, st);
            eg = '0; ec = '0; er = '0; est = '0;
            if (u < nr * p) begin
                int k  = u / p;
                int ph = u % p;
                int rw = k * step;
                er = 128'(rw);
                for (int j = 0; j < step; j++) begin
                    eg[rw + j] = 1'b1;
                    if (ph >= s + 1 && ph <= s + c) ec[rw + j] = 1'b1;
                end
                est = 128'({ph == s, ph == s + c + 1, 1'b0});
            end else begin
                est = 128'(3'b001);
            end
            check(rq_g, "gate", g, eg);
            check((s_in == 0 || c_in == 0) ? "R11" : "R5", "clear", cl, ec);
            check("R6", "row index", r, er);
            check(u == nr * p ? "R7" : "R4", "sig/ped/done", st, est);
            // stray start while busy: must change nothing (checked next cycles)
            if (poke && u == 3 * p + 1) begin
                if (dual) start_b = 1'b1; else start_a = 1'b1;
            end
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            idle_check(dual, "R8");
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20061));
        repeat (2) @(negedge clk);
        idle_check(1'b0, "R1");
        idle_check(1'b1, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check(1'b0, "R1");
        // directed: baseline, zero timing, continuous, stray start
        run(1'b0, 3, 2, 1, 1'b0);
        run(1'b0, 0, 0, 1, 1'b0);   // R11
        run(1'b0, 1, 5, 2, 1'b0);   // R8 continuous
        run(1'b0, 4, 1, 1, 1'b1);   // R9
        run(1'b1, 2, 3, 1, 1'b0);   // R10
        run(1'b1, 0, 4, 2, 1'b1);   // R10, R8, R9
        for (int i = 0; i < 6; i++) begin
            int s = int'($urandom_range(0, 7));
            int c = int'($urandom_range(0, 7));
            bit d = 1'($urandom_range(0, 1));
            int n = int'($urandom_range(1, 2));
            run(d, s, c, n, 1'($urandom_range(0, 1)));
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule